// File: doc/BRIEF.md
# Action-Qualified PWM Waveform Generator

A single-channel PWM timebase paired with a waveform generator. A 16-bit counter advanced by a programmable clock divider runs in up, down or up-down mode against an active period and an active compare value. Four counter events are decoded: bottom (zero), compare while rising, top (period or centre turn) and compare while falling. Each event carries its own 2-bit action code that leaves the output alone, forces it low, forces it high or inverts it.

Period and compare values are written through a shadow stage. One of four load policies moves them into the active copies. They can load at the end of each PWM cycle, at once on write, only after an explicit arming strobe, or also at the centre turn of an up-down cycle. The raw waveform leaves the block together with the counter, its direction and one single-cycle strobe per event for interrupt and trigger logic elsewhere in the chip.

Top module: `pwm_wg_top`

## Requirements
- R1: `cnt_mode_i` selects the count mode: 0 counts up from 0 to the period and wraps to 0, 1 counts down from the period to 0 and reloads the period, 2 counts up to the period and back down to 0 (value 3 behaves as 0). One PWM cycle lasts (P+1) counter steps in modes 0 and 1 and 2·P steps in mode 2, where P is the active period.
- R2: The counter advances once every (`psc_i`+1) clocks while `en_i` is high. `psc_i` is a 12-bit value from 0 to 0xFFF.
- R3: Each action input uses the code 0 for no change, 1 for drive low, 2 for drive high and 3 for invert. The action for an event updates `pwm_o` at the clock edge on which the event strobe is high. The events are: zero (counter at 0), period (counter at the period; in mode 2 only while rising), compare-up (counter at compare while rising, modes 0 and 2) and compare-down (counter at compare while falling, modes 1 and 2).
- R4: When several events coincide, actions are applied in the order zero, period, compare-up, compare-down, and each later action works on the result of the earlier one.
- R5: While the active period is 0 the counter holds at 0 and no event strobe is raised.
- R6: Load policy 0 (`ld_mode_i`=0): a value written with `wr_i` becomes active at the end of the current PWM cycle. In modes 0 and 2 this is when the counter leaves its top or bottom turn; in mode 1 it is when the counter leaves 0.
- R7: Load policy 1: `period_i` and `cmp_i` become active at the clock edge that samples `wr_i`.
- R8: Load policy 2: written values load only at the first cycle end after a `ld_win_i` strobe. Each strobe allows one load.
- R9: Load policy 3: written values load at the centre turn of a mode-2 cycle as well as at each cycle end.
- R10: `cnt_clr_i` sets the counter to 0, the direction to rising and restarts the divider at the next edge, and it takes priority over counting.
- R11: Each event strobe is high for one clock, in the cycle of the divider tick on which it occurs, and never while `en_i` is low. In mode 2 the period event occurs once per cycle.
- R12: After reset `pwm_o` is 0, the counter is 0 and the direction is rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| cnt_mode_i | input | 2 | Count mode (R1) |
| psc_i | input | 12 | Clock divider value, divide by value+1 |
| period_i | input | 16 | Period value to write |
| cmp_i | input | 16 | Compare value to write |
| wr_i | input | 1 | Write strobe for period_i and cmp_i |
| ld_mode_i | input | 2 | Load policy (R6 to R9) |
| ld_win_i | input | 1 | Arming strobe for load policy 2 |
| cnt_clr_i | input | 1 | Counter clear |
| act_zero_i | input | 2 | Action code for the zero event |
| act_cmpu_i | input | 2 | Action code for compare while rising |
| act_prd_i | input | 2 | Action code for the period event |
| act_cmpd_i | input | 2 | Action code for compare while falling |
| pwm_o | output | 1 | Raw waveform |
| cnt_o | output | 16 | Counter value |
| dir_up_o | output | 1 | Counter direction, 1 = rising |
| ev_zero_o | output | 1 | Zero event strobe |
| ev_cmpu_o | output | 1 | Compare-up event strobe |
| ev_prd_o | output | 1 | Period event strobe |
| ev_cmpd_o | output | 1 | Compare-down event strobe |

## Verification
On every cycle the assertions check the following. No strobe fires while counting is disabled or the period is 0. The two compare strobes are never high together. The waveform holds whenever no event strobe was high. A clear forces the counter to 0. A zero event in up mode is followed by a count of 1. Only the bench's scenarios can show the cycle lengths and duty of each count mode under the divider, the order in which coincident actions resolve, and the moment each load policy makes a new period or compare value active.

// File: rtl/pwm_wg_pkg.sv
package pwm_wg_pkg;

  typedef enum logic [1:0] {
    CNT_UP   = 2'd0,
    CNT_DOWN = 2'd1,
    CNT_UPDN = 2'd2
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LD_PERIOD = 2'd0,
    LD_IMM    = 2'd1,
    LD_WINDOW = 2'd2,
    LD_CENTRE = 2'd3
  } ld_mode_e;

  // event slots in action priority order
  localparam int EV_ZERO = 0;
  localparam int EV_PRD  = 1;
  localparam int EV_CMPU = 2;
  localparam int EV_CMPD = 3;
  localparam int N_EV    = 4;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    logic res;
    case (code)
      ACT_LOW:    res = 1'b0;
      ACT_HIGH:   res = 1'b1;
      ACT_TOGGLE: res = ~cur;
      default:    res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pwm_wg_prescaler.sv
module pwm_wg_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;

  // >= keeps the divider from running a full wrap when psc_i shrinks
  assign tick_o = en_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (clr_i || !en_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_wg_timebase.sv
module pwm_wg_timebase
  import pwm_wg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic [N_EV-1:0]  ev_o,
  output logic             bound_o,
  output logic             centre_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             run, is_down, is_ud, is_up;
  logic             at_top, at_bot, at_cmp, rising, live;

  assign run     = (prd_i != '0);
  assign is_down = (mode_i == CNT_DOWN);
  assign is_ud   = (mode_i == CNT_UPDN);
  assign is_up   = !is_down && !is_ud;
  assign at_top  = (cnt_q >= prd_i);
  assign at_bot  = (cnt_q == '0);
  assign at_cmp  = (cnt_q == cmp_i);
  assign rising  = is_up || (is_ud && dir_q);
  assign live    = tick_i && run;

  assign ev_o[EV_ZERO] = live && at_bot;
  assign ev_o[EV_PRD]  = live && (cnt_q == prd_i) && (!is_ud || dir_q);
  assign ev_o[EV_CMPU] = live && at_cmp && rising;
  assign ev_o[EV_CMPD] = live && at_cmp && !rising;

  // end of a PWM cycle; a stopped counter loads on any tick
  assign bound_o  = tick_i && (!run || (is_up && at_top) || (!is_up && at_bot));
  assign centre_o = live && is_ud && dir_q && at_top;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!run) begin
      cnt_d = '0;
      dir_d = 1'b1;
    end else if (is_up) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
      dir_d = 1'b1;
    end else if (is_down) begin
      cnt_d = at_bot ? prd_i : cnt_q - 1'b1;
    end else if (dir_q) begin
      if (at_top) begin
        cnt_d = prd_i - 1'b1;
        dir_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (at_bot) begin
        cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
        dir_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = dir_q;

endmodule

// File: rtl/pwm_wg_shadow.sv
module pwm_wg_shadow
  import pwm_wg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  input  logic [1:0]   policy_i,
  input  logic         win_i,
  input  logic         bound_i,
  input  logic         centre_i,
  output logic [W-1:0] val_o
);

  logic [W-1:0] shd_q, act_q;
  logic         pend_q, armed_q, load;

  always_comb begin
    case (policy_i)
      LD_PERIOD: load = bound_i && pend_q;
      LD_WINDOW: load = bound_i && armed_q;
      LD_CENTRE: load = (bound_i || centre_i) && pend_q;
      default:   load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q   <= '0;
      act_q   <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (load) begin
        act_q   <= shd_q;
        pend_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (win_i) armed_q <= 1'b1;
      if (wr_i) begin
        shd_q <= val_i;
        if (policy_i == LD_IMM) begin
          act_q  <= val_i;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign val_o = act_q;

endmodule

// File: rtl/pwm_wg_action.sv
module pwm_wg_action
  import pwm_wg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_EV-1:0]      ev_i,
  input  logic [N_EV-1:0][1:0] act_i,
  output logic                 pwm_o
);

  logic pwm_q, pwm_d;

  // later slots override earlier ones
  always_comb begin
    pwm_d = pwm_q;
    for (int e = 0; e < N_EV; e++) begin
      if (ev_i[e]) pwm_d = apply_act(act_i[e], pwm_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_wg_top.sv
module pwm_wg_top
  import pwm_wg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       cnt_mode_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_i,
  input  logic [1:0]       ld_mode_i,
  input  logic             ld_win_i,
  input  logic             cnt_clr_i,
  input  logic [1:0]       act_zero_i,
  input  logic [1:0]       act_cmpu_i,
  input  logic [1:0]       act_prd_i,
  input  logic [1:0]       act_cmpd_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             ev_zero_o,
  output logic             ev_cmpu_o,
  output logic             ev_prd_o,
  output logic             ev_cmpd_o
);

  localparam int IDX_PRD = 0;
  localparam int IDX_CMP = 1;
  localparam int N_SHD   = 2;

  logic                        tick, bound, centre;
  logic [N_SHD-1:0][CNT_W-1:0] wr_val, act_val;
  logic [CNT_W-1:0]            prd_act, cmp_act;
  logic [N_EV-1:0]             ev;
  logic [N_EV-1:0][1:0]        act_code;

  pwm_wg_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (cnt_clr_i),
    .psc_i  (psc_i),
    .tick_o (tick)
  );

  assign wr_val[IDX_PRD] = period_i;
  assign wr_val[IDX_CMP] = cmp_i;

  for (genvar g = 0; g < N_SHD; g++) begin : g_shd
    pwm_wg_shadow #(.W(CNT_W)) i_shd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_i),
      .val_i    (wr_val[g]),
      .policy_i (ld_mode_i),
      .win_i    (ld_win_i),
      .bound_i  (bound),
      .centre_i (centre),
      .val_o    (act_val[g])
    );
  end

  assign prd_act = act_val[IDX_PRD];
  assign cmp_act = act_val[IDX_CMP];

  pwm_wg_timebase #(.CNT_W(CNT_W)) i_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clr_i    (cnt_clr_i),
    .mode_i   (cnt_mode_i),
    .prd_i    (prd_act),
    .cmp_i    (cmp_act),
    .cnt_o    (cnt_o),
    .dir_up_o (dir_up_o),
    .ev_o     (ev),
    .bound_o  (bound),
    .centre_o (centre)
  );

  assign act_code[EV_ZERO] = act_zero_i;
  assign act_code[EV_PRD]  = act_prd_i;
  assign act_code[EV_CMPU] = act_cmpu_i;
  assign act_code[EV_CMPD] = act_cmpd_i;

  pwm_wg_action i_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .act_i  (act_code),
    .pwm_o  (pwm_o)
  );

  assign ev_zero_o = ev[EV_ZERO];
  assign ev_prd_o  = ev[EV_PRD];
  assign ev_cmpu_o = ev[EV_CMPU];
  assign ev_cmpd_o = ev[EV_CMPD];

endmodule

// File: rtl/pwm_wg_chk.sv
module pwm_wg_chk
  import pwm_wg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       cnt_mode_i,
  input logic             cnt_clr_i,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_o,
  input logic             ev_zero_o,
  input logic             ev_cmpu_o,
  input logic             ev_prd_o,
  input logic             ev_cmpd_o
);

  logic any_ev;
  assign any_ev = ev_zero_o || ev_cmpu_o || ev_prd_o || ev_cmpd_o;

  p_no_ev_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !any_ev);

  p_stop_no_ev_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_act == '0) |-> !any_ev);

  p_cmp_dir_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_cmpu_o, ev_cmpd_o}));

  p_pwm_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_ev |=> $stable(pwm_o));

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_o == '0));

  p_up_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_zero_o && cnt_mode_i == CNT_UP && !cnt_clr_i) |=> (cnt_o == CNT_W'(1)));

endmodule

bind pwm_wg_top pwm_wg_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cnt_mode_i (cnt_mode_i),
  .cnt_clr_i  (cnt_clr_i),
  .prd_act    (prd_act),
  .cnt_o      (cnt_o),
  .pwm_o      (pwm_o),
  .ev_zero_o  (ev_zero_o),
  .ev_cmpu_o  (ev_cmpu_o),
  .ev_prd_o   (ev_prd_o),
  .ev_cmpd_o  (ev_cmpd_o)
);

// File: tb/test_pwm_wg_top.sv
module test_pwm_wg_top;
  import pwm_wg_pkg::*;

  localparam int CNT_W = 16;
  localparam int PSC_W = 12;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [1:0]       cnt_mode_i = '0;
  logic [PSC_W-1:0] psc_i = '0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] cmp_i = '0;
  logic             wr_i = 1'b0;
  logic [1:0]       ld_mode_i = '0;
  logic             ld_win_i = 1'b0;
  logic             cnt_clr_i = 1'b0;
  logic [1:0]       act_zero_i = '0, act_cmpu_i = '0, act_prd_i = '0, act_cmpd_i = '0;
  logic             pwm_o, dir_up_o, ev_zero_o, ev_cmpu_o, ev_prd_o, ev_cmpd_o;
  logic [CNT_W-1:0] cnt_o;

  always #5 clk = ~clk;

  pwm_wg_top #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_pwm_wg_top (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cnt_mode_i(cnt_mode_i), .psc_i(psc_i),
    .period_i(period_i), .cmp_i(cmp_i), .wr_i(wr_i), .ld_mode_i(ld_mode_i),
    .ld_win_i(ld_win_i), .cnt_clr_i(cnt_clr_i), .act_zero_i(act_zero_i),
    .act_cmpu_i(act_cmpu_i), .act_prd_i(act_prd_i), .act_cmpd_i(act_cmpd_i),
    .pwm_o(pwm_o), .cnt_o(cnt_o), .dir_up_o(dir_up_o), .ev_zero_o(ev_zero_o),
    .ev_cmpu_o(ev_cmpu_o), .ev_prd_o(ev_prd_o), .ev_cmpd_o(ev_cmpd_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // cycle length n and high time h in clocks, hand-derived from R1..R3
  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] psc;
    logic [15:0] prd;
    logic [15:0] cmp;
    logic [1:0]  az, au, ap, ad;
    logic [15:0] exp_n;
    logic [15:0] exp_h;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd0, 16'd9, 16'd4, 2'd2, 2'd1, 2'd0, 2'd0, 16'd10, 16'd4},
    '{2'd0, 12'd2, 16'd5, 16'd2, 2'd2, 2'd1, 2'd0, 2'd0, 16'd18, 16'd6},
    '{2'd0, 12'd0, 16'd3, 16'd1, 2'd1, 2'd2, 2'd0, 2'd0, 16'd4,  16'd3},
    '{2'd1, 12'd0, 16'd7, 16'd3, 2'd0, 2'd0, 2'd2, 2'd1, 16'd8,  16'd4},
    '{2'd1, 12'd1, 16'd4, 16'd1, 2'd0, 2'd0, 2'd2, 2'd1, 16'd10, 16'd6},
    '{2'd2, 12'd0, 16'd6, 16'd2, 2'd0, 2'd2, 2'd0, 2'd1, 16'd12, 16'd8},
    '{2'd2, 12'd3, 16'd3, 16'd1, 2'd0, 2'd2, 2'd0, 2'd1, 16'd24, 16'd16}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [11:0] p, input logic [15:0] prd,
                       input logic [15:0] cmp, input logic [1:0] az, input logic [1:0] au,
                       input logic [1:0] ap, input logic [1:0] ad);
    @(negedge clk);
    cnt_mode_i = m; psc_i = p; period_i = prd; cmp_i = cmp;
    act_zero_i = az; act_cmpu_i = au; act_prd_i = ap; act_cmpd_i = ad;
    ld_mode_i = LD_IMM; wr_i = 1'b1; cnt_clr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; cnt_clr_i = 1'b0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!ev_zero_o);
  endtask

  // from a zero-strobe cycle to the next one; strobes driven before the call last one cycle
  task automatic interval(output int n, output int h, output int p);
    n = 0; h = 0; p = 0;
    do begin
      @(negedge clk);
      wr_i = 1'b0; ld_win_i = 1'b0;
      n++;
      if (pwm_o) h++;
      if (ev_prd_o) p++;
    end while (!ev_zero_o);
  endtask

  task automatic centre_run(input logic [1:0] ld, output int h);
    bit done;
    setup(CNT_UPDN, 12'd0, 16'd6, 16'd2, ACT_NONE, ACT_HIGH, ACT_NONE, ACT_LOW);
    ld_mode_i = ld;
    do @(negedge clk); while (pwm_o);
    do @(negedge clk); while (!pwm_o);
    h = 0; done = 0;
    while (pwm_o) begin
      h++;
      if (!done && cnt_o == 16'd4 && dir_up_o) begin
        cmp_i = 16'd4; wr_i = 1'b1; done = 1;
      end
      @(negedge clk);
      wr_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, h, p, k, bad;
    logic [15:0] c0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", "pwm after reset", pwm_o, 0);
    check("R12", "cnt after reset", cnt_o, 0);
    check("R12", "dir after reset", dir_up_o, 1);
    en_i = 1'b1;

    // R1 R2 R3: vector table
    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].mode, VECS[v].psc, VECS[v].prd, VECS[v].cmp,
            VECS[v].az, VECS[v].au, VECS[v].ap, VECS[v].ad);
      wait_zero(); wait_zero();
      interval(n, h, p);
      check("R1", $sformatf("vec%0d cycle length", v), n, VECS[v].exp_n);
      check("R3", $sformatf("vec%0d high time", v), h, VECS[v].exp_h);
    end

    // R11: one period event per up-down cycle
    setup(CNT_UPDN, 12'd0, 16'd3, 16'd1, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    interval(n, h, p);
    check("R11", "updown period strobes", p, 1);
    check("R1", "updown cycle length", n, 6);

    // R11: strobe width with divider
    setup(CNT_UP, 12'd3, 16'd4, 16'd2, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero();
    @(negedge clk);
    check("R11", "zero strobe one cycle", ev_zero_o, 0);

    // R11: disabled counter holds and raises nothing
    en_i = 1'b0;
    c0 = cnt_o; bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (ev_zero_o || ev_prd_o || ev_cmpu_o || ev_cmpd_o || cnt_o != c0) bad++;
    end
    check("R11", "activity while disabled", bad, 0);
    en_i = 1'b1;

    // R4: coincident zero and compare, compare wins
    setup(CNT_UP, 12'd0, 16'd5, 16'd0, ACT_HIGH, ACT_LOW, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    interval(n, h, p);
    check("R4", "zero H then cmp L", h, 0);
    setup(CNT_UP, 12'd0, 16'd5, 16'd0, ACT_LOW, ACT_HIGH, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    interval(n, h, p);
    check("R4", "zero L then cmp H", h, 6);
    setup(CNT_UP, 12'd0, 16'd5, 16'd5, ACT_NONE, ACT_LOW, ACT_HIGH, ACT_NONE);
    wait_zero(); wait_zero();
    interval(n, h, p);
    check("R4", "period H then cmp L", h, 0);

    // R5: zero period stops counter
    setup(CNT_UP, 12'd0, 16'd0, 16'd0, ACT_TOGGLE, ACT_TOGGLE, ACT_TOGGLE, ACT_TOGGLE);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (ev_zero_o || ev_prd_o || ev_cmpu_o || ev_cmpd_o || cnt_o != 0) bad++;
    end
    check("R5", "activity with period 0", bad, 0);

    // R2: largest divider
    setup(CNT_UP, 12'hFFF, 16'd5, 16'd2, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    k = 0;
    do begin @(negedge clk); k++; end while (cnt_o == 0);
    check("R2", "clocks per step at 0xFFF", k, 4096);

    // R10: counter clear
    setup(CNT_UP, 12'd0, 16'd9, 16'd4, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero();
    repeat (3) @(negedge clk);
    check("R10", "cnt before clear", cnt_o, 3);
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0;
    check("R10", "cnt after clear", cnt_o, 0);
    @(negedge clk);
    check("R10", "cnt restarts", cnt_o, 1);

    // R6: load at period end
    setup(CNT_UP, 12'd0, 16'd9, 16'd4, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    ld_mode_i = LD_PERIOD; period_i = 16'd3; wr_i = 1'b1;
    interval(n, h, p);
    check("R6", "cycle after write", n, 10);
    interval(n, h, p);
    check("R6", "cycle with new period", n, 4);

    // R7: immediate load
    setup(CNT_UP, 12'd0, 16'd9, 16'd4, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    repeat (5) @(negedge clk);
    check("R7", "cnt before write", cnt_o, 5);
    ld_mode_i = LD_IMM; period_i = 16'd3; wr_i = 1'b1;
    interval(n, h, p);
    check("R7", "cycles to wrap", n, 2);
    interval(n, h, p);
    check("R7", "cycle with new period", n, 4);

    // R8: window load
    setup(CNT_UP, 12'd0, 16'd9, 16'd4, ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE);
    wait_zero(); wait_zero();
    ld_mode_i = LD_WINDOW; period_i = 16'd3; wr_i = 1'b1;
    interval(n, h, p);
    check("R8", "unarmed cycle 1", n, 10);
    interval(n, h, p);
    check("R8", "unarmed cycle 2", n, 10);
    ld_win_i = 1'b1;
    interval(n, h, p);
    check("R8", "armed cycle", n, 10);
    interval(n, h, p);
    check("R8", "cycle after load", n, 4);

    // R9: centre load shortens the falling half
    centre_run(LD_CENTRE, h);
    check("R9", "pulse with centre load", h, 6);
    centre_run(LD_PERIOD, h);
    check("R6", "pulse with period-end load", h, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule